// File: doc/BRIEF.md
# Shared-Period Edge-Programmable PWM Unit

A pulse-width modulation unit built around one up-counter and seven match comparators. Comparator 0 fixes the repetition rate for all outputs. It does this by returning the counter to zero and by marking the start of every cycle. The remaining six comparators drive six outputs. Output 1 is always single-edge. Each of outputs 2 to 6 can be switched to double-edge mode. In that mode it takes its set point from the comparator just below it and its clear point from its own comparator. The two points may come in either order, so both high-going and low-going pulses can be made.

Each comparator can carry its own actions when it matches: raise an interrupt pulse, return the counter to zero, or halt the counter. The counter steps either on a one-cycle enable from the peripheral clock domain or on rising edges of an external capture pin. The capture pin is synchronised inside the block.

Top module: `pwm_edge_unit`

## Requirements
- R1: The counter advances by exactly one on each step while `run_i` is high, and it holds its value while `run_i` is low. When `src_sel_i` is 0, a step is any cycle with `tick_i` high.
- R2: When `src_sel_i` is 1, a step happens only on a rising edge of `cap_i`. The edge passes through two synchronising flops and then an edge detector, so the count changes 3 clock edges after `cap_i` rises. A steady level on `cap_i` and `tick_i` both produce no steps.
- R3: Match k happens on a step where the counter equals `match_val_i[16k+15:16k]`. If `match_rst_en_i[k]` is set, the counter goes to 0 on that step instead of incrementing. A reset on match 0 at value P gives a period of P+1 steps.
- R4: A match with `match_stop_en_i[k]` set holds the counter at its present value and raises `stopped_o`. The counter then stays frozen until `run_i` is driven low, which clears `stopped_o`.
- R5: `irq_o[k]` is a one-cycle pulse in the cycle after match k, and only when `match_int_en_i[k]` is set.
- R6: In single-edge mode, output n (`pwm_o[n-1]`) goes high on match 0 and low on match n. Output 1 is always single-edge.
- R7: When `dbl_sel_i[n-2]` is 1, output n (n = 2 to 6) goes high on match n-1 and low on match n. Match 0 then has no effect on it.
- R8: A double-edge output whose clear match comes earlier in the cycle than its set match is low between the two matches and high for the rest of the cycle.
- R9: When the set event and the clear event of an output fall on the same step, the output goes low or stays low.
- R10: During reset, the counter, all outputs, `irq_o` and `stopped_o` are 0.
- R11: A match that carries both the reset and the stop actions leaves the counter at 0, with `stopped_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counter enable; a low level also releases a halt |
| src_sel_i | input | 1 | Step source: 0 = tick_i, 1 = cap_i rising edge |
| tick_i | input | 1 | One-cycle step enable from the peripheral clock |
| cap_i | input | 1 | Asynchronous capture pin |
| match_val_i | input | 112 | Seven 16-bit match values, value k in bits 16k+15:16k |
| match_int_en_i | input | 7 | Per-match interrupt enable |
| match_rst_en_i | input | 7 | Per-match counter reset action |
| match_stop_en_i | input | 7 | Per-match counter halt action |
| dbl_sel_i | input | 5 | Bit n-2 selects double-edge mode for output n |
| cnt_o | output | 16 | Counter value |
| pwm_o | output | 6 | PWM outputs; bit n-1 is output n |
| irq_o | output | 7 | Per-match interrupt pulses |
| stopped_o | output | 1 | Counter halted by a stop action |

## Verification
The edge properties assume that the match values and mode selects stay put during the clock edge on which a step is taken. They can change only between edges. The bench meets this by driving every input on the falling clock edge. Match values are drawn from a small range, so matches, coincident set and clear events, and wraps through the period register all happen often. The interrupt property assumes the enables are sampled together with the match they gate. The random phase holds the enables and modes steady across segments of many cycles, while it toggles `tick_i`, `cap_i` and `run_i` cycle by cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    SRC_TICK = 1'b0,
    SRC_CAP  = 1'b1
  } step_src_e;
endpackage

// File: rtl/pwm_step_gen.sv
module pwm_step_gen
  import pwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_sel_i,
  input  logic tick_i,
  input  logic cap_i,
  output logic step_o
);
  logic [2:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= '0;
    else         cap_q <= {cap_q[1:0], cap_i};
  end

  // cap_q[1] is the synchronised level, cap_q[2] its delayed copy
  always_comb begin
    if (step_src_e'(src_sel_i) == SRC_CAP) step_o = cap_q[1] & ~cap_q[2];
    else                                   step_o = tick_i;
  end
endmodule

// File: rtl/pwm_match_cmp.sv
module pwm_match_cmp #(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 7
) (
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic                     adv_i,
  input  logic [N_MATCH*CNT_W-1:0] match_val_i,
  output logic [N_MATCH-1:0]       evt_o
);
  for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp
    assign evt_o[k] = adv_i && (cnt_i == match_val_i[k*CNT_W +: CNT_W]);
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               step_i,
  input  logic [N_MATCH-1:0] evt_i,
  input  logic [N_MATCH-1:0] rst_en_i,
  input  logic [N_MATCH-1:0] stop_en_i,
  output logic               adv_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               halted_o
);
  logic do_rst, do_stop;

  assign adv_o   = run_i & ~halted_o & step_i;
  assign do_rst  = |(evt_i & rst_en_i);
  assign do_stop = |(evt_i & stop_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      halted_o <= 1'b0;
    end else begin
      if (!run_i)       halted_o <= 1'b0;
      else if (do_stop) halted_o <= 1'b1;
      if (adv_o) begin
        if (do_rst)       cnt_o <= '0;
        else if (!do_stop) cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_out_ch.sv
module pwm_out_ch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pwm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pwm_o <= 1'b0;
    else if (clr_i)  pwm_o <= 1'b0;  // clear has priority
    else if (set_i)  pwm_o <= 1'b1;
  end
endmodule

// File: rtl/pwm_edge_unit.sv
module pwm_edge_unit #(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     run_i,
  input  logic                     src_sel_i,
  input  logic                     tick_i,
  input  logic                     cap_i,
  input  logic [N_MATCH*CNT_W-1:0] match_val_i,
  input  logic [N_MATCH-1:0]       match_int_en_i,
  input  logic [N_MATCH-1:0]       match_rst_en_i,
  input  logic [N_MATCH-1:0]       match_stop_en_i,
  input  logic [N_MATCH-3:0]       dbl_sel_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic [N_MATCH-2:0]       pwm_o,
  output logic [N_MATCH-1:0]       irq_o,
  output logic                     stopped_o
);
  localparam int N_OUT = N_MATCH - 1;

  logic               step, adv;
  logic [N_MATCH-1:0] evt;

  pwm_step_gen u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_sel_i (src_sel_i),
    .tick_i    (tick_i),
    .cap_i     (cap_i),
    .step_o    (step)
  );

  pwm_counter #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .step_i    (step),
    .evt_i     (evt),
    .rst_en_i  (match_rst_en_i),
    .stop_en_i (match_stop_en_i),
    .adv_o     (adv),
    .cnt_o     (cnt_o),
    .halted_o  (stopped_o)
  );

  pwm_match_cmp #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_cmp (
    .cnt_i       (cnt_o),
    .adv_i       (adv),
    .match_val_i (match_val_i),
    .evt_o       (evt)
  );

  for (genvar c = 0; c < N_OUT; c++) begin : g_ch
    logic set_ev;
    if (c == 0) begin : g_single
      assign set_ev = evt[0];
    end else begin : g_sel
      assign set_ev = dbl_sel_i[c-1] ? evt[c] : evt[0];
    end
    pwm_out_ch u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_ev),
      .clr_i  (evt[c+1]),
      .pwm_o  (pwm_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= evt & match_int_en_i;
  end
endmodule

// File: rtl/pwm_edge_unit_chk.sv
module pwm_edge_unit_chk #(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 7
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     run_i,
  input logic                     src_sel_i,
  input logic                     tick_i,
  input logic                     cap_i,
  input logic [N_MATCH*CNT_W-1:0] match_val_i,
  input logic [N_MATCH-1:0]       match_int_en_i,
  input logic [N_MATCH-1:0]       match_rst_en_i,
  input logic [N_MATCH-1:0]       match_stop_en_i,
  input logic [N_MATCH-3:0]       dbl_sel_i,
  input logic [CNT_W-1:0]         cnt_o,
  input logic [N_MATCH-2:0]       pwm_o,
  input logic [N_MATCH-1:0]       irq_o,
  input logic                     stopped_o
);
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_o));

  a_r4_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |=> $stable(cnt_o));

  a_r3_drop_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o < $past(cnt_o)) |-> (cnt_o == '0));

  a_r5_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |irq_o |-> ((irq_o & ~$past(match_int_en_i)) == '0));

  for (genvar c = 0; c < N_MATCH - 1; c++) begin : g_ch
    a_r9_no_rise_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwm_o[c]) |-> ($past(cnt_o) != $past(match_val_i[(c+1)*CNT_W +: CNT_W])));
    a_r6_fall_own_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pwm_o[c]) |-> ($past(cnt_o) == $past(match_val_i[(c+1)*CNT_W +: CNT_W])));
  end
endmodule

bind pwm_edge_unit pwm_edge_unit_chk #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_chk (.*);

// File: tb/sim_pwm_edge_unit.sv
`timescale 1ns/1ps
module sim_pwm_edge_unit;
  localparam int CW = 16;
  localparam int NM = 7;
  localparam int NO = NM - 1;

  logic              clk = 0, rst_ni = 0;
  logic              run = 0, src = 0, tick = 0, cap = 0;
  logic [NM*CW-1:0]  mv = '0;
  logic [NM-1:0]     int_en = '0, rst_en = '0, stop_en = '0;
  logic [NM-3:0]     dbl = '0;
  logic [CW-1:0]     cnt;
  logic [NO-1:0]     pwm;
  logic [NM-1:0]     irq;
  logic              stopped;

  int checks = 0, fails = 0;
  int acc_hi [NO];
  int acc_zero;

  // reference state
  logic [CW-1:0] m_cnt = '0;
  logic          m_halt = 0;
  logic [NO-1:0] m_pwm = '0;
  logic [NM-1:0] m_irq = '0;
  logic [2:0]    m_cap = '0;

  always #2 clk = ~clk;

  pwm_edge_unit #(.CNT_W(CW), .N_MATCH(NM)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .src_sel_i(src), .tick_i(tick),
    .cap_i(cap), .match_val_i(mv), .match_int_en_i(int_en),
    .match_rst_en_i(rst_en), .match_stop_en_i(stop_en), .dbl_sel_i(dbl),
    .cnt_o(cnt), .pwm_o(pwm), .irq_o(irq), .stopped_o(stopped)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] mval(input int k);
    return mv[k*CW +: CW];
  endfunction

  // next reference state from the requirements, using the inputs seen at the coming edge
  task automatic model_step();
    logic          stp, adv, do_rst, do_stop;
    logic [NM-1:0] ev;
    stp = src ? (m_cap[1] & ~m_cap[2]) : tick;
    adv = run & ~m_halt & stp;
    for (int k = 0; k < NM; k++) ev[k] = adv && (m_cnt == mval(k));
    do_rst  = |(ev & rst_en);
    do_stop = |(ev & stop_en);
    for (int c = 0; c < NO; c++) begin
      logic s;
      s = (c > 0 && dbl[c-1]) ? ev[c] : ev[0];
      if (ev[c+1]) m_pwm[c] = 1'b0;
      else if (s)  m_pwm[c] = 1'b1;
    end
    m_irq = ev & int_en;
    if (adv) begin
      if (do_rst)        m_cnt = '0;
      else if (!do_stop) m_cnt = m_cnt + 1'b1;
    end
    if (!run)         m_halt = 1'b0;
    else if (do_stop) m_halt = 1'b1;
    m_cap = {m_cap[1:0], cap};
  endtask

  task automatic compare();
    chk("R1 count", cnt, m_cnt);
    chk("R6 outputs", pwm, m_pwm);
    chk("R5 irq", irq, m_irq);
    chk("R4 stopped", stopped, m_halt);
    for (int c = 0; c < NO; c++) if (pwm[c]) acc_hi[c]++;
    if (cnt == 0) acc_zero++;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic clear_acc();
    for (int c = 0; c < NO; c++) acc_hi[c] = 0;
    acc_zero = 0;
  endtask

  task automatic setv(input int k, input int v);
    mv[k*CW +: CW] = CW'(v);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R10 reset count", cnt, 0);
    chk("R10 reset outputs", pwm, 0);
    chk("R10 reset irq", irq, 0);
    chk("R10 reset stopped", stopped, 0);
    rst_ni = 1;

    // single-edge: period 10 steps
    run = 1; tick = 1; rst_en[0] = 1; int_en = '1;
    setv(0, 9); setv(1, 3); setv(2, 9); setv(3, 0);
    setv(4, 20); setv(5, 20); setv(6, 20);
    run_cycles(20); clear_acc(); run_cycles(10);
    chk("R3 one wrap per period", acc_zero, 1);
    chk("R6 single high for match+1", acc_hi[0], 4);
    chk("R9 set and clear together", acc_hi[1], 0);
    chk("R6 clear at zero", acc_hi[2], 1);
    chk("R6 no clear match", acc_hi[3], 10);

    // double-edge modes
    dbl = 5'b00111;
    setv(1, 6); setv(2, 2); setv(3, 7); setv(4, 7);
    run_cycles(20); clear_acc(); run_cycles(10);
    chk("R6 single follows match1", acc_hi[0], 7);
    chk("R8 negative pulse high time", acc_hi[1], 6);
    chk("R7 positive pulse high time", acc_hi[2], 5);
    chk("R9 double coincident edges", acc_hi[3], 0);
    dbl = '0;

    // stop action
    setv(5, 4); stop_en[5] = 1;
    run_cycles(20);
    chk("R4 halted value", cnt, 4);
    chk("R4 stopped flag", stopped, 1);
    stop_en = '0; run = 0;
    run_cycles(1);
    chk("R4 release", stopped, 0);
    run = 1;
    run_cycles(3);
    chk("R1 resumes", cnt, 7);

    // stop together with reset
    stop_en[0] = 1;
    run_cycles(20);
    chk("R11 stop with reset count", cnt, 0);
    chk("R11 stop with reset flag", stopped, 1);
    stop_en = '0; run = 0; run_cycles(1); run = 1;

    // capture pin stepping
    setv(0, 1000); src = 1; tick = 1;
    run_cycles(4);
    base = int'(cnt);
    chk("R2 tick ignored on capture source", cnt, base);
    cap = 1;
    run_cycles(2);
    chk("R2 no step before sync", cnt, base);
    run_cycles(1);
    chk("R2 step after three edges", cnt, base + 1);
    run_cycles(5);
    chk("R2 level does not step", cnt, base + 1);
    cap = 0; run_cycles(4);

    // random segments
    for (int seg = 0; seg < 60; seg++) begin
      run = 0; run_cycles(1);
      for (int k = 0; k < NM; k++) setv(k, $urandom_range(0, 15));
      int_en  = NM'($urandom);
      rst_en  = NM'($urandom) | NM'(1);
      stop_en = ($urandom_range(0, 3) == 0) ? NM'(1 << $urandom_range(1, NM-1)) : '0;
      dbl     = (NM-2)'($urandom);
      src     = ($urandom_range(0, 3) == 0);
      for (int i = 0; i < 60; i++) begin
        run  = ($urandom_range(0, 9) != 0);
        tick = ($urandom_range(0, 9) < 7);
        cap  = $urandom_range(0, 1);
        run_cycles(1);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule